// File: doc/BRIEF.md
# DSP Instruction Class and Operand Field Decoder

This block takes one 32-bit instruction word per cycle, each with a valid strobe, from a fixed-width DSP instruction set. It sorts the word into one of five classes and reports the addressing mode. It also splits out every operand field that software or a later pipeline stage needs: register numbers, the direct address or immediate, the long and short indirect descriptors, the register selections of parallel pairs, and the load-data-page special form. Mapping register numbers to names, choosing mnemonics and formatting text are left to the consumer.

The class field has a variable length. When the top bit is set, two top bits pick between the two parallel classes. When it is clear, three top bits pick between the two-operand, three-operand and branch classes. The long indirect descriptor fills 16 bits and carries a displacement. The short descriptor fills 8 bits and has none. Both layouts are decoded in parallel, and the consumer uses the one that the class calls for.

The parameter `OUT_REG` chooses between a purely combinational decoder and a decoder with one output register stage. In the registered build, the field outputs load only on valid input cycles and hold at all other times.

Top module: `dsp_word_decoder`

## Requirements
- R1: The class code is 3 for a word with bits [31:30]=10 (parallel multiply-add) and 2 for bits [31:30]=11 (parallel store). With bit 31 clear, bits [31:29] of 000 or 010 give 0 (two-operand), 001 gives 1 (three-operand) and 011 gives 4 (branch).
- R2: `amode` always equals bits [22:21] of the word: 00 register, 01 direct, 10 indirect, 11 immediate.
- R3: `dst_reg` is bits [20:16], `src_reg` is bits [4:0] and `imm16` is bits [15:0], all passed out unchanged.
- R4: The long indirect outputs are `lmod` = bits [15:11], `lar` = bits [10:8] and `ldisp` = bits [7:0].
- R5: Operand A is byte [7:0] and operand B is byte [15:8]. Each has a register number (low 5 bits of the byte) and a short descriptor (modify code = byte bits [7:3], auxiliary register = byte bits [2:0]). For class 1 only, `a_ind` = amode bit 1 and `b_ind` = amode bit 0. Both flags are 0 for every other class.
- R6: `ldp` is 1 exactly when bits [31:8] equal 0x087000. `ldp_page` is then bits [7:0] shifted left by 16; otherwise it is 0.
- R7: `pr16`, `pr19` and `pr22` are the 3-bit fields at bit offsets 16, 19 and 22.
- R8: For class 3 only, `pdst_a` is 1 if bit 23 is set and 0 otherwise, `pdst_b` is 3 if bit 22 is set and 2 otherwise, and `route` is bits [25:24]. For every other class all three are 0.
- R9: With `OUT_REG`=1, the outputs show the decode of a valid word one cycle after it is presented, and `out_valid` equals the previous cycle's `in_valid`. The field outputs hold while `in_valid` is low. With `OUT_REG`=0, the outputs follow the input in the same cycle and `out_valid` equals `in_valid`.
- R10: With `OUT_REG`=1, reset clears `out_valid` and all field outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded outputs valid |
| cls | output | 3 | Class code |
| amode | output | 2 | Addressing mode bits |
| dst_reg | output | 5 | Destination register number |
| src_reg | output | 5 | Register source number |
| imm16 | output | 16 | Direct address or immediate |
| lmod | output | 5 | Long descriptor modify code |
| lar | output | 3 | Long descriptor auxiliary register |
| ldisp | output | 8 | Long descriptor displacement |
| a_reg | output | 5 | Operand A register number |
| a_ind | output | 1 | Operand A is indirect |
| a_mod | output | 5 | Operand A short modify code |
| a_ar | output | 3 | Operand A auxiliary register |
| b_reg | output | 5 | Operand B register number |
| b_ind | output | 1 | Operand B is indirect |
| b_mod | output | 5 | Operand B short modify code |
| b_ar | output | 3 | Operand B auxiliary register |
| pr16 | output | 3 | Parallel register field at offset 16 |
| pr19 | output | 3 | Parallel register field at offset 19 |
| pr22 | output | 3 | Parallel register field at offset 22 |
| route | output | 2 | Multiply-add operand routing |
| pdst_a | output | 2 | Multiply-add first destination register |
| pdst_b | output | 2 | Multiply-add second destination register |
| ldp | output | 1 | Load-data-page form detected |
| ldp_page | output | 24 | Page value of the load-data-page form |

## Verification
The bench builds two copies of the decoder side by side: one with `OUT_REG`=1 and one with `OUT_REG`=0. The same words are fed to both. The registered copy exposes the reset state, the one-cycle latency and the hold of fields while the strobe is low. The combinational copy shows the same decode in the cycle the word arrives and shows `out_valid` following the strobe directly. The chosen words reach every class value, including both two-operand prefixes and both three-operand indirect combinations. They also include the load-data-page pattern next to a word that differs from it in one bit.

// File: rtl/dsp_word_decoder.sv
module dsp_word_decoder #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        out_valid,
  output logic [2:0]  cls,
  output logic [1:0]  amode,
  output logic [4:0]  dst_reg,
  output logic [4:0]  src_reg,
  output logic [15:0] imm16,
  output logic [4:0]  lmod,
  output logic [2:0]  lar,
  output logic [7:0]  ldisp,
  output logic [4:0]  a_reg,
  output logic        a_ind,
  output logic [4:0]  a_mod,
  output logic [2:0]  a_ar,
  output logic [4:0]  b_reg,
  output logic        b_ind,
  output logic [4:0]  b_mod,
  output logic [2:0]  b_ar,
  output logic [2:0]  pr16,
  output logic [2:0]  pr19,
  output logic [2:0]  pr22,
  output logic [1:0]  route,
  output logic [1:0]  pdst_a,
  output logic [1:0]  pdst_b,
  output logic        ldp,
  output logic [23:0] ldp_page
);
  localparam int DW = 120;

  logic [2:0]  c_cls;
  logic        c_three, c_madd, c_ldp;
  logic [DW-1:0] dec, q;

  always_comb begin
    if (in_word[31]) c_cls = in_word[30] ? 3'd2 : 3'd3;
    else case (in_word[30:29])
      2'b01:   c_cls = 3'd1;
      2'b11:   c_cls = 3'd4;
      default: c_cls = 3'd0;
    endcase
  end

  assign c_three = (c_cls == 3'd1);
  assign c_madd  = (c_cls == 3'd3);
  assign c_ldp   = (in_word[31:8] == 24'h087000);

  assign dec = {
    c_cls,
    in_word[22:21],
    in_word[20:16],
    in_word[4:0],
    in_word[15:0],
    in_word[15:11], in_word[10:8], in_word[7:0],
    in_word[4:0],  c_three & in_word[22], in_word[7:3],   in_word[2:0],
    in_word[12:8], c_three & in_word[21], in_word[15:11], in_word[10:8],
    in_word[18:16], in_word[21:19], in_word[24:22],
    c_madd ? in_word[25:24] : 2'b00,
    c_madd ? {1'b0, in_word[23]} : 2'b00,
    c_madd ? {1'b1, in_word[22]} : 2'b00,
    c_ldp,
    c_ldp ? {in_word[7:0], 16'h0000} : 24'h000000
  };

  generate
    if (OUT_REG) begin : g_reg
      logic [DW-1:0] r;
      logic          v;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r <= '0;
          v <= 1'b0;
        end else begin
          v <= in_valid;
          if (in_valid) r <= dec;
        end
      end
      assign q = r;
      assign out_valid = v;
    end else begin : g_comb
      assign q = dec;
      assign out_valid = in_valid;
    end
  endgenerate

  assign {cls, amode, dst_reg, src_reg, imm16, lmod, lar, ldisp,
          a_reg, a_ind, a_mod, a_ar, b_reg, b_ind, b_mod, b_ar,
          pr16, pr19, pr22, route, pdst_a, pdst_b, ldp, ldp_page} = q;
endmodule

module dsp_word_decoder_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic [2:0]  cls,
  input logic [4:0]  dst_reg,
  input logic [15:0] imm16,
  input logic        a_ind,
  input logic        b_ind,
  input logic [1:0]  pdst_b,
  input logic        ldp
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed) |-> out_valid == $past(in_valid));

  p_valid_comb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !OUT_REG |-> out_valid == in_valid);

  p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && !$past(in_valid)) |-> ($stable(dst_reg) && $stable(imm16) && $stable(cls)));

  p_fields_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && armed && $past(in_valid)) |-> (dst_reg == $past(in_word[20:16]) && imm16 == $past(in_word[15:0])));

  p_ind_three_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ind || b_ind) |-> cls == 3'd1);

  p_pdst_madd_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdst_b != 2'd0) |-> cls == 3'd3);

  p_ldp_two_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ldp |-> cls == 3'd0);

  p_cls_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cls <= 3'd4);
endmodule

bind dsp_word_decoder dsp_word_decoder_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .cls(cls), .dst_reg(dst_reg), .imm16(imm16),
  .a_ind(a_ind), .b_ind(b_ind), .pdst_b(pdst_b), .ldp(ldp)
);

// File: tb/sim_dsp_word_decoder.sv
module sim_dsp_word_decoder;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  int checks = 0, failures = 0;

  always #(PERIOD/2) clk = ~clk;

  logic        v0, v1;
  logic [2:0]  cls0, cls1;
  logic [1:0]  am0, am1;
  logic [4:0]  dst0, dst1, src0, src1;
  logic [15:0] imm0, imm1;
  logic [4:0]  lm0, lm1;  logic [2:0] la0, la1;  logic [7:0] ld0, ld1;
  logic [4:0]  ar0, ar1;  logic ai0, ai1;  logic [4:0] am_0, am_1;  logic [2:0] aa0, aa1;
  logic [4:0]  br0, br1;  logic bi0, bi1;  logic [4:0] bm0, bm1;  logic [2:0] ba0, ba1;
  logic [2:0]  p160, p161, p190, p191, p220, p221;
  logic [1:0]  rt0, rt1, pa0, pa1, pb0, pb1;
  logic        ldp0, ldp1;
  logic [23:0] pg0, pg1;

  dsp_word_decoder #(.OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(v0), .cls(cls0), .amode(am0), .dst_reg(dst0), .src_reg(src0),
    .imm16(imm0), .lmod(lm0), .lar(la0), .ldisp(ld0),
    .a_reg(ar0), .a_ind(ai0), .a_mod(am_0), .a_ar(aa0),
    .b_reg(br0), .b_ind(bi0), .b_mod(bm0), .b_ar(ba0),
    .pr16(p160), .pr19(p190), .pr22(p220), .route(rt0),
    .pdst_a(pa0), .pdst_b(pb0), .ldp(ldp0), .ldp_page(pg0));

  dsp_word_decoder #(.OUT_REG(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(v1), .cls(cls1), .amode(am1), .dst_reg(dst1), .src_reg(src1),
    .imm16(imm1), .lmod(lm1), .lar(la1), .ldisp(ld1),
    .a_reg(ar1), .a_ind(ai1), .a_mod(am_1), .a_ar(aa1),
    .b_reg(br1), .b_ind(bi1), .b_mod(bm1), .b_ar(ba1),
    .pr16(p161), .pr19(p191), .pr22(p221), .route(rt1),
    .pdst_a(pa1), .pdst_b(pb1), .ldp(ldp1), .ldp_page(pg1));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R10 out_valid after reset", {31'b0, v0}, 0);
    chk("R10 cls after reset", {29'b0, cls0}, 0);
    chk("R10 imm16 after reset", {16'b0, imm0}, 0);
  endtask

  task automatic t_two_op_direct();
    drive(32'h0025_1234);
    chk("R9 comb valid", {31'b0, v1}, 1);
    chk("R1 comb cls two-op", {29'b0, cls1}, 0);
    chk("R2 comb amode direct", {30'b0, am1}, 1);
    step();
    chk("R9 reg valid", {31'b0, v0}, 1);
    chk("R1 cls two-op 000", {29'b0, cls0}, 0);
    chk("R2 amode direct", {30'b0, am0}, 1);
    chk("R3 dst_reg", {27'b0, dst0}, 5);
    chk("R3 src_reg", {27'b0, src0}, 32'h14);
    chk("R3 imm16", {16'b0, imm0}, 32'h1234);
    chk("R4 lmod", {27'b0, lm0}, 2);
    chk("R4 lar", {29'b0, la0}, 2);
    chk("R4 ldisp", {24'b0, ld0}, 32'h34);
  endtask

  task automatic t_hold();
    in_valid = 1'b0;
    in_word  = 32'h4045_A6FF;
    #1;
    chk("R9 comb valid low", {31'b0, v1}, 0);
    step();
    chk("R9 reg valid low", {31'b0, v0}, 0);
    chk("R9 dst held", {27'b0, dst0}, 5);
    chk("R9 imm held", {16'b0, imm0}, 32'h1234);
  endtask

  task automatic t_two_op_indirect();
    drive(32'h4045_A6FF);
    step();
    chk("R1 cls two-op 010", {29'b0, cls0}, 0);
    chk("R2 amode indirect", {30'b0, am0}, 2);
    chk("R4 lmod long", {27'b0, lm0}, 32'h14);
    chk("R4 lar long", {29'b0, la0}, 6);
    chk("R4 ldisp long", {24'b0, ld0}, 32'hFF);
    chk("R5 a_ind zero for two-op", {31'b0, ai0}, 0);
  endtask

  task automatic t_three_both_ind();
    drive(32'h2063_9A2B);
    chk("R1 comb cls three", {29'b0, cls1}, 1);
    step();
    chk("R1 cls three", {29'b0, cls0}, 1);
    chk("R3 three dst", {27'b0, dst0}, 3);
    chk("R5 a_ind mode11", {31'b0, ai0}, 1);
    chk("R5 b_ind mode11", {31'b0, bi0}, 1);
    chk("R5 a_mod", {27'b0, am_0}, 5);
    chk("R5 a_ar", {29'b0, aa0}, 3);
    chk("R5 b_mod", {27'b0, bm0}, 32'h13);
    chk("R5 b_ar", {29'b0, ba0}, 2);
    chk("R5 a_reg", {27'b0, ar0}, 32'h0B);
    chk("R5 b_reg", {27'b0, br0}, 32'h1A);
  endtask

  task automatic t_three_mode01();
    drive(32'h2021_9A2B);
    chk("R5 comb a_ind mode01", {31'b0, ai1}, 0);
    chk("R5 comb b_ind mode01", {31'b0, bi1}, 1);
    step();
    chk("R5 a_ind mode01", {31'b0, ai0}, 0);
    chk("R5 b_ind mode01", {31'b0, bi0}, 1);
  endtask

  task automatic t_branch();
    drive(32'h6000_0010);
    step();
    chk("R1 cls branch", {29'b0, cls0}, 4);
    chk("R8 pdst_b zero for branch", {30'b0, pb0}, 0);
  endtask

  task automatic t_ldp();
    drive(32'h0870_00C5);
    step();
    chk("R6 ldp flag", {31'b0, ldp0}, 1);
    chk("R6 ldp page", {8'b0, pg0}, 32'hC5_0000);
    chk("R2 amode imm", {30'b0, am0}, 3);
    drive(32'h0870_01C5);
    chk("R6 comb near-miss", {31'b0, ldp1}, 0);
    step();
    chk("R6 near-miss flag", {31'b0, ldp0}, 0);
    chk("R6 near-miss page", {8'b0, pg0}, 0);
  endtask

  task automatic t_muladd();
    drive(32'h82D3_4567);
    chk("R8 comb route", {30'b0, rt1}, 2);
    step();
    chk("R1 cls muladd", {29'b0, cls0}, 3);
    chk("R8 route", {30'b0, rt0}, 2);
    chk("R8 pdst_a", {30'b0, pa0}, 1);
    chk("R8 pdst_b", {30'b0, pb0}, 3);
    chk("R7 pr16", {29'b0, p160}, 3);
    chk("R7 pr19", {29'b0, p190}, 2);
    chk("R7 pr22", {29'b0, p220}, 3);
    drive(32'h8000_0000);
    step();
    chk("R8 pdst_a clear", {30'b0, pa0}, 0);
    chk("R8 pdst_b clear", {30'b0, pb0}, 2);
    chk("R8 route zero", {30'b0, rt0}, 0);
  endtask

  task automatic t_par_store();
    drive(32'hC09A_0000);
    step();
    chk("R1 cls par store", {29'b0, cls0}, 2);
    chk("R7 store pr16", {29'b0, p160}, 2);
    chk("R7 store pr19", {29'b0, p190}, 3);
    chk("R7 store pr22", {29'b0, p220}, 2);
    chk("R8 store pdst_a", {30'b0, pa0}, 0);
    chk("R8 store route", {30'b0, rt0}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_two_op_direct();
    t_hold();
    t_two_op_indirect();
    t_three_both_ind();
    t_three_mode01();
    t_branch();
    t_ldp();
    t_muladd();
    t_par_store();
    @(negedge clk);
    in_valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule